// File: doc/BRIEF.md
# Sleep Mode Power Controller

This controller moves a system between a running state and four low-power states. It also brings the system back to run when a wake source that the current state honours fires. Software asks for a low-power state by raising `sleep_req` together with a two-bit mode code. From then on the controller drives five control lines that would steer the power switches, the reset tree, the CPU and the sleep timer:

- `cpu_halt`
- `core_pwr_en`
- `periph_rst`
- `debug_keep`
- `sleep_tmr_en`

The four low-power states are:

- **Idle.** Only the CPU stops.
- **Emulated deep sleep.** Peripherals are held in reset while the core domain and the debug logic stay alive.
- **Deep sleep with timer.** The core domain is switched off, but the sleep timer keeps running.
- **Deepest sleep.** The timer is stopped as well, so only external events can end it.

On a wake from either powered-down state, the core domain is switched on first. The controller then holds peripheral reset for a fixed number of cycles before returning to run.

All inputs are synchronous to `clk`. The control lines are registered, so each one changes on the same clock edge as the internal state.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: After reset the block is in run: cpu_halt=0, core_pwr_en=1, periph_rst=0, debug_keep=1, sleep_tmr_en=1.
- R2: Idle state (mode code 0) drives cpu_halt=1, core_pwr_en=1, periph_rst=0, debug_keep=1, sleep_tmr_en=1. It returns to run on the edge after irq_pending is seen high, and ext_wake and tmr_wake do not end it.
- R3: Emulated deep sleep (mode code 1) drives cpu_halt=1, core_pwr_en=1, periph_rst=1, debug_keep=1, sleep_tmr_en=1. Any ext_wake bit or tmr_wake returns it directly to run on the next edge.
- R4: Deep sleep with timer (mode code 2) drives cpu_halt=1, core_pwr_en=0, periph_rst=1, debug_keep=0, sleep_tmr_en=1. Any ext_wake bit or tmr_wake ends it.
- R5: Deepest sleep (mode code 3) drives cpu_halt=1, core_pwr_en=0, periph_rst=1, debug_keep=0, sleep_tmr_en=0. Only an ext_wake bit ends it.
- R6: tmr_wake has no effect in deepest sleep.
- R7: A wake from mode 2 or 3 enters a power-up phase lasting exactly RST_DLY cycles, with cpu_halt=1, core_pwr_en=1, periph_rst=1, debug_keep=1, sleep_tmr_en=1. Run follows.
- R8: A sleep request is ignored if a wake that the requested mode honours is pending in the same cycle. For mode 0 that is irq_pending; for modes 1 and 2 it is ext_wake or tmr_wake; for mode 3 it is ext_wake alone.
- R9: The mode code selects the target state: 0 idle, 1 emulated deep sleep, 2 deep sleep with timer, 3 deepest sleep. A request is taken on the edge where sleep_req=1 is seen in run.
- R10: sleep_req is ignored outside run, and wake inputs have no effect in run.
- R11: irq_pending does not end any of the three deep states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_req | input | 1 | Request to enter the state named by sleep_mode |
| sleep_mode | input | 2 | Requested low-power state code |
| irq_pending | input | 1 | Some interrupt is pending |
| ext_wake | input | NUM_EXT | External wake events, one per bit |
| tmr_wake | input | 1 | Sleep timer wake event |
| cpu_halt | output | 1 | CPU stopped |
| core_pwr_en | output | 1 | Core power domain switched on |
| periph_rst | output | 1 | Peripherals held in reset |
| debug_keep | output | 1 | Debug logic kept alive |
| sleep_tmr_en | output | 1 | Sleep timer running |

## Verification
The checker watches the relationships among the control lines on every cycle:

- Powering down always comes with halt and reset.
- A stopped timer only occurs with the core off, and it persists until an external event arrives.
- Power returns with reset still held, and reset only drops once power has been on for at least a cycle.
- Idle ends on an interrupt, and run is kept without a request.

The exact length of the power-up phase, the mode decoding, and the refusal of a request when a qualified wake is pending depend on the state history. Only the bench's scenarios show these, by comparing every cycle with a reference model.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_EMU    = 3'd2,
    ST_DEEP   = 3'd3,
    ST_DEEPER = 3'd4,
    ST_PWRUP  = 3'd5
  } spc_state_e;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_EMU    = 2'd1,
    MODE_DEEP   = 2'd2,
    MODE_DEEPER = 2'd3
  } spc_mode_e;

  typedef struct packed {
    logic halt;
    logic pwr;
    logic prst;
    logic dbg;
    logic tmr;
  } spc_ctl_t;

  localparam int unsigned NUM_MODES = 4;

  function automatic spc_state_e spc_target(spc_mode_e m);
    case (m)
      MODE_IDLE:   return ST_IDLE;
      MODE_EMU:    return ST_EMU;
      MODE_DEEP:   return ST_DEEP;
      default:     return ST_DEEPER;
    endcase
  endfunction

  function automatic spc_ctl_t spc_decode(spc_state_e s);
    spc_ctl_t c;
    case (s)
      ST_RUN:    c = '{halt: 1'b0, pwr: 1'b1, prst: 1'b0, dbg: 1'b1, tmr: 1'b1};
      ST_IDLE:   c = '{halt: 1'b1, pwr: 1'b1, prst: 1'b0, dbg: 1'b1, tmr: 1'b1};
      ST_EMU:    c = '{halt: 1'b1, pwr: 1'b1, prst: 1'b1, dbg: 1'b1, tmr: 1'b1};
      ST_DEEP:   c = '{halt: 1'b1, pwr: 1'b0, prst: 1'b1, dbg: 1'b0, tmr: 1'b1};
      ST_DEEPER: c = '{halt: 1'b1, pwr: 1'b0, prst: 1'b1, dbg: 1'b0, tmr: 1'b0};
      default:   c = '{halt: 1'b1, pwr: 1'b1, prst: 1'b1, dbg: 1'b1, tmr: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/spc_wake_qual.sv
module spc_wake_qual #(
  parameter int unsigned NUM_EXT = 4
) (
  input  logic                                irq_pending,
  input  logic [NUM_EXT-1:0]                  ext_wake,
  input  logic                                tmr_wake,
  output logic [spc_pkg::NUM_MODES-1:0]       wake_by_mode
);
  import spc_pkg::*;

  logic any_ext;

  assign any_ext = |ext_wake;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam spc_mode_e MODE = spc_mode_e'(m);
    if (MODE == MODE_IDLE) begin : g_idle
      assign wake_by_mode[m] = irq_pending;
    end else if (MODE == MODE_DEEPER) begin : g_deeper
      assign wake_by_mode[m] = any_ext;
    end else begin : g_timed
      assign wake_by_mode[m] = any_ext | tmr_wake;
    end
  end

endmodule

// File: rtl/spc_seq_timer.sv
module spc_seq_timer #(
  parameter int unsigned RST_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  output logic done
);
  localparam int unsigned CW = (RST_DLY > 1) ? $clog2(RST_DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_ld;

  always_comb begin
    cnt_ld = clr | cnt_en;
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == LAST);

endmodule

// File: rtl/spc_fsm.sv
module spc_fsm (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sleep_req,
  input  logic [1:0]                    sleep_mode,
  input  logic [spc_pkg::NUM_MODES-1:0] wake_by_mode,
  input  logic                          seq_done,
  output spc_pkg::spc_state_e           state_q,
  output spc_pkg::spc_state_e           state_d,
  output logic                          seq_clr,
  output logic                          seq_en
);
  import spc_pkg::*;

  spc_mode_e req_mode;
  logic      req_ok;

  assign req_mode = spc_mode_e'(sleep_mode);
  assign req_ok   = sleep_req & ~wake_by_mode[req_mode];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:    if (req_ok)                   state_d = spc_target(req_mode);
      ST_IDLE:   if (wake_by_mode[MODE_IDLE])   state_d = ST_RUN;
      ST_EMU:    if (wake_by_mode[MODE_EMU])    state_d = ST_RUN;
      ST_DEEP:   if (wake_by_mode[MODE_DEEP])   state_d = ST_PWRUP;
      ST_DEEPER: if (wake_by_mode[MODE_DEEPER]) state_d = ST_PWRUP;
      ST_PWRUP:  if (seq_done)                  state_d = ST_RUN;
      default:                                  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  assign seq_clr = (state_d == ST_PWRUP) && (state_q != ST_PWRUP);
  assign seq_en  = (state_q == ST_PWRUP);

endmodule

// File: rtl/spc_out_reg.sv
module spc_out_reg (
  input  logic                clk,
  input  logic                rst_n,
  input  spc_pkg::spc_state_e state_q,
  input  spc_pkg::spc_state_e state_d,
  output spc_pkg::spc_ctl_t   ctl_q
);
  import spc_pkg::*;

  logic     ld;
  spc_ctl_t ctl_d;

  assign ld    = (state_d != state_q);
  assign ctl_d = spc_decode(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= spc_decode(ST_RUN);
    end else if (ld) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl #(
  parameter int unsigned NUM_EXT = 4,
  parameter int unsigned RST_DLY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic [1:0]         sleep_mode,
  input  logic               irq_pending,
  input  logic [NUM_EXT-1:0] ext_wake,
  input  logic               tmr_wake,
  output logic               cpu_halt,
  output logic               core_pwr_en,
  output logic               periph_rst,
  output logic               debug_keep,
  output logic               sleep_tmr_en
);
  import spc_pkg::*;

  logic [NUM_MODES-1:0] wake_by_mode;
  spc_state_e           state_q;
  spc_state_e           state_d;
  logic                 seq_clr;
  logic                 seq_en;
  logic                 seq_done;
  spc_ctl_t             ctl_q;

  spc_wake_qual #(.NUM_EXT(NUM_EXT)) u_qual (
    .irq_pending  (irq_pending),
    .ext_wake     (ext_wake),
    .tmr_wake     (tmr_wake),
    .wake_by_mode (wake_by_mode)
  );

  spc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .sleep_mode   (sleep_mode),
    .wake_by_mode (wake_by_mode),
    .seq_done     (seq_done),
    .state_q      (state_q),
    .state_d      (state_d),
    .seq_clr      (seq_clr),
    .seq_en       (seq_en)
  );

  spc_seq_timer #(.RST_DLY(RST_DLY)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (seq_clr),
    .cnt_en (seq_en),
    .done   (seq_done)
  );

  spc_out_reg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .state_d (state_d),
    .ctl_q   (ctl_q)
  );

  assign cpu_halt     = ctl_q.halt;
  assign core_pwr_en  = ctl_q.pwr;
  assign periph_rst   = ctl_q.prst;
  assign debug_keep   = ctl_q.dbg;
  assign sleep_tmr_en = ctl_q.tmr;

endmodule

// File: rtl/sleep_pwr_ctrl_chk.sv
module sleep_pwr_ctrl_chk #(
  parameter int unsigned NUM_EXT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sleep_req,
  input logic               irq_pending,
  input logic [NUM_EXT-1:0] ext_wake,
  input logic               cpu_halt,
  input logic               core_pwr_en,
  input logic               periph_rst,
  input logic               debug_keep,
  input logic               sleep_tmr_en
);

  // R4: powered-down core always comes with halt, reset and no debug
  a_r4_off_is_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_en |-> (cpu_halt && periph_rst && !debug_keep));

  // R5: stopped timer only with core off
  a_r5_tmr_off_core_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_tmr_en |-> !core_pwr_en);

  // R6: deepest sleep persists without an external event
  a_r6_timer_cannot_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_tmr_en && (ext_wake == '0)) |=> !sleep_tmr_en);

  // R7: power returns with reset and halt still held
  a_r7_power_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pwr_en) |-> (periph_rst && cpu_halt && debug_keep && sleep_tmr_en));

  // R7: reset drops only after power was already on
  a_r7_release_after_power: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_rst) |-> (core_pwr_en && $past(core_pwr_en)));

  // R2: idle ends on a pending interrupt
  a_r2_idle_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && !periph_rst && irq_pending) |=> !cpu_halt);

  // R10: run is kept without a request
  a_r10_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt && !sleep_req) |=> !cpu_halt);

endmodule

bind sleep_pwr_ctrl sleep_pwr_ctrl_chk #(.NUM_EXT(NUM_EXT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_req    (sleep_req),
  .irq_pending  (irq_pending),
  .ext_wake     (ext_wake),
  .cpu_halt     (cpu_halt),
  .core_pwr_en  (core_pwr_en),
  .periph_rst   (periph_rst),
  .debug_keep   (debug_keep),
  .sleep_tmr_en (sleep_tmr_en)
);

// File: tb/sleep_pwr_ctrl_tb.sv
module sleep_pwr_ctrl_tb;

  localparam int unsigned NE  = 4;
  localparam int unsigned DLY = 4;

  localparam int M_RUN = 0, M_IDLE = 1, M_EMU = 2, M_DEEP = 3, M_DEEPER = 4, M_PUP = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_req;
  logic [1:0]    sleep_mode;
  logic          irq_pending;
  logic [NE-1:0] ext_wake;
  logic          tmr_wake;
  logic          cpu_halt, core_pwr_en, periph_rst, debug_keep, sleep_tmr_en;

  int errors = 0;
  int checks = 0;
  int mst    = M_RUN;
  int mcnt   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sleep_pwr_ctrl #(.NUM_EXT(NE), .RST_DLY(DLY)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .sleep_mode   (sleep_mode),
    .irq_pending  (irq_pending),
    .ext_wake     (ext_wake),
    .tmr_wake     (tmr_wake),
    .cpu_halt     (cpu_halt),
    .core_pwr_en  (core_pwr_en),
    .periph_rst   (periph_rst),
    .debug_keep   (debug_keep),
    .sleep_tmr_en (sleep_tmr_en)
  );

  // expected {halt, pwr, prst, dbg, tmr} per state
  function automatic logic [4:0] exp_ctl(int s);
    case (s)
      M_RUN:    return 5'b01011;
      M_IDLE:   return 5'b11011;
      M_EMU:    return 5'b11111;
      M_DEEP:   return 5'b10101;
      M_DEEPER: return 5'b10100;
      default:  return 5'b11111;
    endcase
  endfunction

  function automatic bit qual(int m, bit irq, bit ext, bit tmr);
    case (m)
      0:       return irq;
      3:       return ext;
      default: return ext | tmr;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      M_RUN:    return "R10";
      M_IDLE:   return "R2";
      M_EMU:    return "R3";
      M_DEEP:   return "R4";
      M_DEEPER: return "R5";
      default:  return "R7";
    endcase
  endfunction

  task automatic step(bit req, int mode, bit irq, logic [NE-1:0] ext, bit tmr, string tag);
    bit   e = |ext;
    int   ns = mst;
    int   nc = mcnt;
    logic [4:0] act;
    logic [4:0] ex;
    string t;
    sleep_req   = req;
    sleep_mode  = mode[1:0];
    irq_pending = irq;
    ext_wake    = ext;
    tmr_wake    = tmr;
    case (mst)
      M_RUN:    if (req && !qual(mode, irq, e, tmr)) ns = M_IDLE + mode;
      M_IDLE:   if (irq) ns = M_RUN;
      M_EMU:    if (e | tmr) ns = M_RUN;
      M_DEEP:   if (e | tmr) begin ns = M_PUP; nc = 0; end
      M_DEEPER: if (e) begin ns = M_PUP; nc = 0; end
      default:  if (mcnt == DLY - 1) ns = M_RUN; else nc = mcnt + 1;
    endcase
    @(posedge clk);
    #1;
    mst  = ns;
    mcnt = nc;
    act  = {cpu_halt, core_pwr_en, periph_rst, debug_keep, sleep_tmr_en};
    ex   = exp_ctl(mst);
    t    = (tag == "") ? tag_of(mst) : tag;
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: outputs got %b expected %b (state %0d)", t, act, ex, mst);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; sleep_req = 0; sleep_mode = 0; irq_pending = 0; ext_wake = '0; tmr_wake = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({cpu_halt, core_pwr_en, periph_rst, debug_keep, sleep_tmr_en} !== 5'b01011) begin
      errors++;
      $display("FAIL R1: reset outputs got %b expected %b",
               {cpu_halt, core_pwr_en, periph_rst, debug_keep, sleep_tmr_en}, 5'b01011);
    end
    rst_n = 1'b1;
    step(0, 0, 0, '0, 0, "R1");
    // R10: wake inputs in run do nothing
    step(0, 2, 1, 4'hF, 1, "R10");
    // R9 / R2: idle, ignores ext and timer, wakes on irq
    step(1, 0, 0, '0, 0, "R9");
    step(0, 0, 0, 4'h2, 1, "R2");
    step(0, 0, 1, '0, 0, "R2");
    // R3: emulated deep sleep, timer wakes straight to run
    step(1, 1, 0, '0, 0, "R9");
    step(1, 3, 1, '0, 0, "R10");
    step(0, 0, 0, '0, 1, "R3");
    // R4 / R11 / R7: deep sleep, irq ignored, ext wakes through power-up
    step(1, 2, 0, '0, 0, "R9");
    step(0, 0, 1, '0, 0, "R11");
    step(0, 0, 0, 4'h8, 0, "R7");
    for (int i = 0; i < DLY; i++) step(0, 0, 0, '0, 0, "R7");
    // R5 / R6: deepest sleep, timer ignored
    step(1, 3, 0, '0, 0, "R9");
    step(0, 0, 0, '0, 1, "R6");
    step(0, 0, 1, '0, 1, "R11");
    step(0, 0, 0, 4'h1, 0, "R5");
    for (int i = 0; i < DLY; i++) step(0, 0, 0, '0, 0, "R7");
    // R8: request refused when its own wake is pending
    step(1, 1, 0, '0, 1, "R8");
    step(1, 0, 1, '0, 0, "R8");
    step(1, 2, 0, 4'h4, 0, "R8");
    step(1, 3, 0, 4'h2, 0, "R8");
    step(1, 3, 0, '0, 1, "R8");
    step(0, 0, 0, 4'h1, 0, "R5");
    for (int i = 0; i < DLY; i++) step(0, 0, 0, '0, 0, "R7");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit r  = ($urandom % 4) == 0;
      int md = $urandom % 4;
      bit q  = ($urandom % 8) == 0;
      logic [NE-1:0] x = (($urandom % 8) == 0) ? NE'($urandom) : '0;
      bit tm = ($urandom % 8) == 0;
      step(r, md, q, x, tm, "");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule